// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits in front of a small word-addressed memory. It turns pairs of load-exclusive and store-exclusive requests into atomic read-modify-write sequences. Up to `N_MASTERS` requesters share the memory, and each one presents at most one request per cycle. Each request carries an opcode, a context tag, a byte address and write data. A requester can be a CPU context, an interrupt handler or a DMA engine. The monitor keeps one reservation slot per requester. A load-exclusive arms the slot on the addressed word. A later store-exclusive writes only if that slot is still armed for the same word and the same context. The store-exclusive then reports a one-bit status: 0 means the store happened, 1 means it was refused.

Each reservation slot is a two-state machine. The states are OPEN and EXCLUSIVE, and every slot enters OPEN on reset. Each cycle a priority resolver issues one of three commands to each slot:

- ARM: OPEN to EXCLUSIVE, or a reload of EXCLUSIVE with a new word and context.
- HOLD: the slot stays in its current state.
- DROP: EXCLUSIVE to OPEN.

A conflicting access triggers DROP. The resolver steps through the requesters in ascending ID order inside the cycle. Each request therefore sees the reservations and memory contents that all lower-ID requests of the same cycle left behind. Responses are registered and appear exactly one cycle after the request.

Top module: `exmon_top`

## Requirements
- R1: After reset every slot is OPEN, all response outputs read 0, and a store-exclusive with no preceding load-exclusive returns status 1.
- R2: A load-exclusive returns the current word. A store-exclusive that follows it from the same requester, with the same context and word, returns status 0 and writes the word.
- R3: A store-exclusive that returns status 1 leaves memory unchanged. `rsp_fail` is only ever 1 for a store-exclusive.
- R4: Every store-exclusive, whether it passes or fails, returns the issuer's slot to OPEN, so a second store-exclusive fails.
- R5: Addresses are compared per 32-bit word, and address bits [1:0] are ignored. A store-exclusive to a word other than the armed one fails and does not write.
- R6: A plain store or a passing store-exclusive by another requester to the armed word drops the reservation. Loads by other requesters, and writes to other words, leave it armed.
- R7: Any access by the same requester with a different context tag to the armed word drops the reservation. A store-exclusive whose context differs from the armed one fails.
- R8: A new load-exclusive from a requester that is already EXCLUSIVE replaces the armed word.
- R9: Same-cycle requests are evaluated in ascending requester ID. A passing store-exclusive drops the matching reservations of higher IDs before they are evaluated. A load sees data written by lower IDs in the same cycle. When two requesters store to one word in the same cycle, the highest ID's data is kept.
- R10: The response for each request follows it by exactly one cycle. A load or load-exclusive returns the word in `rsp_rdata`, and a store of either kind returns 0 there.
- R11: `clr_excl` forces every slot to OPEN before the same cycle's requests are evaluated. A load-exclusive in that cycle still arms its slot.

Opcode encoding (2 bits per requester, `req_op`): 00 load, 01 store, 10 load-exclusive, 11 store-exclusive. Bit 0 set marks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_excl | input | 1 | Force all reservations to OPEN |
| req_valid | input | N_MASTERS | Request present, one bit per requester |
| req_op | input | 2*N_MASTERS | Opcode per requester |
| req_ctx | input | CTX_W*N_MASTERS | Context tag per requester |
| req_addr | input | ADDR_W*N_MASTERS | Byte address per requester |
| req_wdata | input | DATA_W*N_MASTERS | Write data per requester |
| rsp_valid | output | N_MASTERS | Response present, one cycle after request |
| rsp_fail | output | N_MASTERS | Store-exclusive status, 1 = refused |
| rsp_rdata | output | DATA_W*N_MASTERS | Read data per requester |

## Verification
The bench first aims at interference. It issues plain stores from a second requester, passing store-exclusives from a rival, and same-requester accesses under another context, while keeping harmless loads and writes to neighbouring words. A monitor with wrong clear rules would either let a stale store-exclusive through and overwrite the interfering data, or refuse a legitimate one. Same-cycle collisions test the ordering: a resolver that evaluates all requests against the start-of-cycle state would pass both competing store-exclusives, miss the forwarded data, or keep the wrong writer. Clear-input cases check that the clear is applied before the requests in its cycle. Cases with a misaligned address and with a replaced address check that word matching uses the latest armed word and ignores the byte offset.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LDEX  = 2'b10,
        OP_STEX  = 2'b11
    } op_e;

    typedef enum logic {
        RSV_OPEN = 1'b0,
        RSV_EXCL = 1'b1
    } rsv_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'b00,
        CMD_ARM  = 2'b01,
        CMD_DROP = 2'b10
    } cmd_e;

endpackage

// File: rtl/exmon_slot.sv
module exmon_slot
    import exmon_pkg::*;
#(
    parameter int WORD_W = 6,
    parameter int CTX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [WORD_W-1:0] arm_word,
    input  logic [CTX_W-1:0]  arm_ctx,
    output rsv_e              state,
    output logic [WORD_W-1:0] word,
    output logic [CTX_W-1:0]  ctx
);

    rsv_e state_nxt;

    // Transition logic: ARM opens a reservation, DROP closes it, HOLD keeps it
    always_comb begin
        state_nxt = state;
        unique case (state)
            RSV_OPEN: if (cmd == CMD_ARM)  state_nxt = RSV_EXCL;
            RSV_EXCL: if (cmd == CMD_DROP) state_nxt = RSV_OPEN;
            default:  state_nxt = RSV_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RSV_OPEN;
        else        state <= state_nxt;
    end

    // Watched word and owning context, loaded on every ARM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            ctx  <= '0;
        end else if (cmd == CMD_ARM) begin
            word <= arm_word;
            ctx  <= arm_ctx;
        end
    end

endmodule

// File: rtl/exmon_resolve.sv
module exmon_resolve
    import exmon_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int WORD_W    = 6,
    parameter int CTX_W     = 2
) (
    input  logic              clr,
    input  logic              valid    [N_MASTERS],
    input  op_e               op       [N_MASTERS],
    input  logic [WORD_W-1:0] word     [N_MASTERS],
    input  logic [CTX_W-1:0]  ctx      [N_MASTERS],
    input  rsv_e              cur_st   [N_MASTERS],
    input  logic [WORD_W-1:0] cur_word [N_MASTERS],
    input  logic [CTX_W-1:0]  cur_ctx  [N_MASTERS],
    output cmd_e              cmd      [N_MASTERS],
    output logic              wr_en    [N_MASTERS],
    output logic              pass     [N_MASTERS]
);

    rsv_e              rs_st [N_MASTERS];
    logic [WORD_W-1:0] rs_w  [N_MASTERS];
    logic [CTX_W-1:0]  rs_c  [N_MASTERS];
    logic              armed [N_MASTERS];
    logic              hit   [N_MASTERS];
    logic              own   [N_MASTERS];

    // Requests walk through the slots in ascending ID; each sees what lower IDs left
    always_comb begin
        for (int i = 0; i < N_MASTERS; i++) begin
            rs_st[i] = clr ? RSV_OPEN : cur_st[i];
            rs_w[i]  = cur_word[i];
            rs_c[i]  = cur_ctx[i];
            armed[i] = 1'b0;
            wr_en[i] = 1'b0;
            pass[i]  = 1'b0;
            hit[i]   = 1'b0;
            own[i]   = 1'b0;
        end
        for (int m = 0; m < N_MASTERS; m++) begin
            if (valid[m]) begin
                hit[m] = (rs_st[m] == RSV_EXCL) && (rs_w[m] == word[m]);
                own[m] = hit[m] && (rs_c[m] == ctx[m]);
                unique case (op[m])
                    OP_LDEX: begin
                        rs_st[m] = RSV_EXCL;
                        rs_w[m]  = word[m];
                        rs_c[m]  = ctx[m];
                        armed[m] = 1'b1;
                    end
                    OP_LOAD: begin
                        if (hit[m] && !own[m]) rs_st[m] = RSV_OPEN;
                    end
                    OP_STORE: begin
                        wr_en[m] = 1'b1;
                        if (hit[m] && !own[m]) rs_st[m] = RSV_OPEN;
                    end
                    OP_STEX: begin
                        pass[m]  = own[m];
                        wr_en[m] = own[m];
                        rs_st[m] = RSV_OPEN;
                    end
                    default: ;
                endcase
                if (wr_en[m]) begin
                    for (int j = 0; j < N_MASTERS; j++) begin
                        if (j != m && rs_st[j] == RSV_EXCL && rs_w[j] == word[m])
                            rs_st[j] = RSV_OPEN;
                    end
                end
            end
        end
        for (int i = 0; i < N_MASTERS; i++) begin
            if (rs_st[i] == RSV_EXCL) cmd[i] = armed[i] ? CMD_ARM : CMD_HOLD;
            else                      cmd[i] = CMD_DROP;
        end
    end

endmodule

// File: rtl/exmon_mem.sv
module exmon_mem #(
    parameter int N_MASTERS = 4,
    parameter int WORD_W    = 6,
    parameter int DATA_W    = 32,
    localparam int WORDS    = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en [N_MASTERS],
    input  logic [WORD_W-1:0] word  [N_MASTERS],
    input  logic [DATA_W-1:0] wdata [N_MASTERS],
    output logic [DATA_W-1:0] rdata [N_MASTERS]
);

    logic [DATA_W-1:0] mem [WORDS];

    // Writes applied in ascending ID; the last assignment (highest ID) wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            for (int m = 0; m < N_MASTERS; m++)
                if (wr_en[m]) mem[word[m]] <= wdata[m];
        end
    end

    // Reads see writes of lower IDs issued in the same cycle
    always_comb begin
        for (int m = 0; m < N_MASTERS; m++) begin
            rdata[m] = mem[word[m]];
            for (int k = 0; k < m; k++)
                if (wr_en[k] && word[k] == word[m]) rdata[m] = wdata[k];
        end
    end

endmodule

// File: rtl/exmon_top.sv
module exmon_top
    import exmon_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CTX_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_excl,
    input  logic [N_MASTERS-1:0]          req_valid,
    input  logic [2*N_MASTERS-1:0]        req_op,
    input  logic [CTX_W*N_MASTERS-1:0]    req_ctx,
    input  logic [ADDR_W*N_MASTERS-1:0]   req_addr,
    input  logic [DATA_W*N_MASTERS-1:0]   req_wdata,
    output logic [N_MASTERS-1:0]          rsp_valid,
    output logic [N_MASTERS-1:0]          rsp_fail,
    output logic [DATA_W*N_MASTERS-1:0]   rsp_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    logic              v_a    [N_MASTERS];
    op_e               op_a   [N_MASTERS];
    logic [WORD_W-1:0] word_a [N_MASTERS];
    logic [CTX_W-1:0]  ctx_a  [N_MASTERS];
    logic [DATA_W-1:0] wd_a   [N_MASTERS];
    rsv_e              st_a   [N_MASTERS];
    logic [WORD_W-1:0] sw_a   [N_MASTERS];
    logic [CTX_W-1:0]  sc_a   [N_MASTERS];
    cmd_e              cmd_a  [N_MASTERS];
    logic              wr_a   [N_MASTERS];
    logic              pass_a [N_MASTERS];
    logic [DATA_W-1:0] rd_a   [N_MASTERS];

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_lane
        assign v_a[g]    = req_valid[g];
        assign op_a[g]   = op_e'(req_op[2*g +: 2]);
        assign word_a[g] = req_addr[g*ADDR_W + 2 +: WORD_W];
        assign ctx_a[g]  = req_ctx[g*CTX_W +: CTX_W];
        assign wd_a[g]   = req_wdata[g*DATA_W +: DATA_W];

        exmon_slot #(.WORD_W(WORD_W), .CTX_W(CTX_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_a[g]),
            .arm_word (word_a[g]),
            .arm_ctx  (ctx_a[g]),
            .state    (st_a[g]),
            .word     (sw_a[g]),
            .ctx      (sc_a[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_valid[g]                 <= 1'b0;
                rsp_fail[g]                  <= 1'b0;
                rsp_rdata[g*DATA_W +: DATA_W] <= '0;
            end else begin
                rsp_valid[g]                 <= v_a[g];
                rsp_fail[g]                  <= v_a[g] && op_a[g] == OP_STEX && !pass_a[g];
                rsp_rdata[g*DATA_W +: DATA_W] <= (v_a[g] && !op_a[g][0]) ? rd_a[g] : '0;
            end
        end
    end

    exmon_resolve #(.N_MASTERS(N_MASTERS), .WORD_W(WORD_W), .CTX_W(CTX_W)) u_resolve (
        .clr      (clr_excl),
        .valid    (v_a),
        .op       (op_a),
        .word     (word_a),
        .ctx      (ctx_a),
        .cur_st   (st_a),
        .cur_word (sw_a),
        .cur_ctx  (sc_a),
        .cmd      (cmd_a),
        .wr_en    (wr_a),
        .pass     (pass_a)
    );

    exmon_mem #(.N_MASTERS(N_MASTERS), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_a),
        .word  (word_a),
        .wdata (wd_a),
        .rdata (rd_a)
    );

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
    parameter int N_MASTERS = 4,
    parameter int DATA_W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr_excl,
    input logic [N_MASTERS-1:0]        req_valid,
    input logic [2*N_MASTERS-1:0]      req_op,
    input logic [N_MASTERS-1:0]        rsp_valid,
    input logic [N_MASTERS-1:0]        rsp_fail,
    input logic [DATA_W*N_MASTERS-1:0] rsp_rdata
);

    logic seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        rsp_valid == $past(req_valid));

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_chk
        // R3
        fail_only_stex_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            rsp_fail[g] |-> $past(req_valid[g] && req_op[2*g +: 2] == 2'b11));

        // R11
        clr_before_stex_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_excl && req_valid[g] && req_op[2*g +: 2] == 2'b11) |=> rsp_fail[g]);

        // R4
        stex_twice_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            (req_valid[g] && req_op[2*g +: 2] == 2'b11
             && $past(req_valid[g] && req_op[2*g +: 2] == 2'b11)) |=> rsp_fail[g]);

        // R10
        store_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
            (rsp_valid[g] && $past(req_op[2*g])) |-> rsp_rdata[g*DATA_W +: DATA_W] == '0);
    end

endmodule

bind exmon_top exmon_chk #(.N_MASTERS(N_MASTERS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/exmon_top_test.sv
module exmon_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 2;

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, LX = 2'b10, SX = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_excl = 1'b0;
    logic [NM-1:0]     req_valid = '0;
    logic [2*NM-1:0]   req_op = '0;
    logic [CW*NM-1:0]  req_ctx = '0;
    logic [AW*NM-1:0]  req_addr = '0;
    logic [DW*NM-1:0]  req_wdata = '0;
    logic [NM-1:0]     rsp_valid;
    logic [NM-1:0]     rsp_fail;
    logic [DW*NM-1:0]  rsp_rdata;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int          m;
        bit          fail;
        logic [31:0] rd;
    } exp_t;
    exp_t  q[$];
    string tq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exmon_top #(.N_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW), .CTX_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr_excl(clr_excl),
        .req_valid(req_valid), .req_op(req_op), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata)
    );

    task automatic put(input int m, input logic [1:0] op, input int ctx, input int addr,
                       input logic [31:0] wd, input bit ef, input logic [31:0] er,
                       input string tag);
        exp_t e;
        req_valid[m]          = 1'b1;
        req_op[2*m +: 2]      = op;
        req_ctx[CW*m +: CW]   = CW'(ctx);
        req_addr[AW*m +: AW]  = AW'(addr);
        req_wdata[DW*m +: DW] = wd;
        e.m = m; e.fail = ef; e.rd = er;
        q.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        clr_excl  = 1'b0;
    endtask

    task automatic one(input int m, input logic [1:0] op, input int ctx, input int addr,
                       input logic [31:0] wd, input bit ef, input logic [31:0] er,
                       input string tag);
        put(m, op, ctx, addr, wd, ef, er, tag);
        step();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < NM; m++) begin
                if (rsp_valid[m]) begin
                    n_chk++;
                    if (q.size() == 0) begin
                        n_err++;
                        $display("FAIL R10 unexpected response on lane %0d: actual valid expected none", m);
                    end else begin
                        exp_t  e;
                        string t;
                        e = q.pop_front();
                        t = tq.pop_front();
                        if (e.m != m || rsp_fail[m] != e.fail || rsp_rdata[DW*m +: DW] != e.rd) begin
                            n_err++;
                            $display("FAIL %s lane %0d: actual fail=%0d rdata=%h expected lane %0d fail=%0d rdata=%h",
                                     t, m, rsp_fail[m], rsp_rdata[DW*m +: DW], e.m, e.fail, e.rd);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog expired: actual hung expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state of outputs
        n_chk++;
        if (rsp_valid != '0 || rsp_fail != '0 || rsp_rdata != '0) begin
            n_err++;
            $display("FAIL R1 reset outputs: actual %b/%b expected 0/0", rsp_valid, rsp_fail);
        end

        // R1 / R3: store-exclusive without arming fails and does not write
        one(0, SX, 0, 'h10, 32'hAA, 1, 0, "R1");
        one(0, LD, 0, 'h10, 0, 0, 0, "R3");
        // R2 / R5 / R4
        one(0, LX, 0, 'h10, 0, 0, 0, "R2");
        one(0, SX, 0, 'h13, 32'h1111, 0, 0, "R5");
        one(0, LD, 0, 'h10, 0, 0, 32'h1111, "R2");
        one(0, SX, 0, 'h10, 32'h2222, 1, 0, "R4");
        one(0, LD, 0, 'h10, 0, 0, 32'h1111, "R4");
        // R5 other word
        one(1, LX, 0, 'h20, 0, 0, 0, "R5");
        one(1, SX, 0, 'h24, 32'h5, 1, 0, "R5");
        one(1, LD, 0, 'h24, 0, 0, 0, "R5");
        // R6 global interference
        one(0, LX, 0, 'h30, 0, 0, 0, "R6");
        one(1, LD, 0, 'h30, 0, 0, 0, "R6");
        one(2, ST, 0, 'h34, 32'h9, 0, 0, "R6");
        one(0, SX, 0, 'h30, 32'h7, 0, 0, "R6");
        one(0, LX, 0, 'h30, 0, 0, 32'h7, "R6");
        one(1, ST, 0, 'h31, 32'h8, 0, 0, "R6");
        one(0, SX, 0, 'h30, 32'h77, 1, 0, "R6");
        one(0, LD, 0, 'h30, 0, 0, 32'h8, "R6");
        one(0, LX, 0, 'h38, 0, 0, 0, "R6");
        one(1, LX, 0, 'h38, 0, 0, 0, "R6");
        one(1, SX, 0, 'h38, 32'h3, 0, 0, "R6");
        one(0, SX, 0, 'h38, 32'h4, 1, 0, "R6");
        one(0, LD, 0, 'h38, 0, 0, 32'h3, "R6");
        // R7 local context scope
        one(2, LX, 1, 'h40, 0, 0, 0, "R7");
        one(2, LD, 2, 'h40, 0, 0, 0, "R7");
        one(2, SX, 1, 'h40, 32'h1, 1, 0, "R7");
        one(2, LX, 1, 'h40, 0, 0, 0, "R7");
        one(2, SX, 3, 'h40, 32'h2, 1, 0, "R7");
        one(2, LD, 1, 'h40, 0, 0, 0, "R7");
        one(2, LX, 1, 'h40, 0, 0, 0, "R7");
        one(2, SX, 1, 'h40, 32'h42, 0, 0, "R7");
        one(2, LD, 1, 'h40, 0, 0, 32'h42, "R7");
        // R8 replace
        one(3, LX, 0, 'h50, 0, 0, 0, "R8");
        one(3, LX, 0, 'h54, 0, 0, 0, "R8");
        one(3, SX, 0, 'h50, 32'h1, 1, 0, "R8");
        one(3, LX, 0, 'h50, 0, 0, 0, "R8");
        one(3, LX, 0, 'h54, 0, 0, 0, "R8");
        one(3, SX, 0, 'h54, 32'h2, 0, 0, "R8");
        one(3, LD, 0, 'h50, 0, 0, 0, "R8");
        one(3, LD, 0, 'h54, 0, 0, 32'h2, "R8");
        // R9 same-cycle ordering
        put(0, LX, 0, 'h60, 0, 0, 0, "R9");
        put(1, LX, 0, 'h60, 0, 0, 0, "R9");
        step();
        put(0, SX, 0, 'h60, 32'hA, 0, 0, "R9");
        put(1, SX, 0, 'h60, 32'hB, 1, 0, "R9");
        step();
        one(2, LD, 0, 'h60, 0, 0, 32'hA, "R9");
        put(0, ST, 0, 'h64, 32'h1, 0, 0, "R9");
        put(1, LD, 0, 'h64, 0, 0, 32'h1, "R9");
        put(2, ST, 0, 'h64, 32'h2, 0, 0, "R9");
        put(3, LD, 0, 'h64, 0, 0, 32'h2, "R9");
        step();
        one(0, LD, 0, 'h64, 0, 0, 32'h2, "R9");
        put(1, ST, 0, 'h68, 32'h3, 0, 0, "R9");
        put(3, ST, 0, 'h68, 32'h4, 0, 0, "R9");
        step();
        one(2, LD, 0, 'h68, 0, 0, 32'h4, "R9");
        one(0, LX, 0, 'h6C, 0, 0, 0, "R9");
        put(0, SX, 0, 'h6C, 32'h5, 0, 0, "R9");
        put(1, ST, 0, 'h6C, 32'h6, 0, 0, "R9");
        step();
        one(0, LD, 0, 'h6C, 0, 0, 32'h6, "R9");
        // R11 clear input
        one(1, LX, 0, 'h74, 0, 0, 0, "R11");
        clr_excl = 1'b1;
        step();
        one(1, SX, 0, 'h74, 32'h1, 1, 0, "R11");
        one(1, LX, 0, 'h74, 0, 0, 0, "R11");
        clr_excl = 1'b1;
        one(1, SX, 0, 'h74, 32'h2, 1, 0, "R11");
        clr_excl = 1'b1;
        one(1, LX, 0, 'h74, 0, 0, 0, "R11");
        one(1, SX, 0, 'h74, 32'h3, 0, 0, "R11");
        one(1, LD, 0, 'h74, 0, 0, 32'h3, "R11");

        repeat (3) step();
        n_chk++;
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL R10 missing responses: actual %0d pending expected 0", q.size());
        end
        report();
        $finish;
    end

endmodule